// File: doc/BRIEF.md
# SPI Port Pin Router with Wait-Mode Clock Hold

This block sits between the pads of a four-pin serial peripheral port and the shift logic behind it. From a control register and a direction/port-data register, it works out which of the four pads (slave data out, master data out, serial clock, slave select) the block drives. It also decides what each driven pad carries and which pad feeds the shifter's receive input. In the four-wire arrangement, the master and slave data lines each carry one direction. In the single-wire arrangement, one data pad is shared for transmit and receive, and the data pad left over becomes a plain general-purpose I/O driven from the port-data register.

The block also contains the serial clock edge generator. It toggles the clock on each enabled baud tick, counts edges for one frame, and holds the clock level and edge count while the chip is in wait mode, if the hold bit is set. When wait mode ends, the frame continues from the same edge, so the frame still has exactly twice as many edges as it has bits.

Top module: `spi_pin_router`

## Requirements
- R1: After reset both registers read 0 and no pad is driven. A write to address 0 (control) or address 1 (direction in bits 3:0, port data in bits 7:4, bit index = pin index MISO 0, MOSI 1, SCK 2, SS 3) reads back unchanged on the next cycle.
- R2: Control bits: bit 0 master, bit 1 single-wire, bit 2 select-output enable, bit 3 LSB-first, bit 4 wait hold. In four-wire mode the MISO pad is driven with `sh_stx` only when its direction bit is 1, master is 0 and the SS pad reads low.
- R3: In four-wire mode the MOSI pad is driven with `sh_mtx` only when its direction bit is 1 and master is 1.
- R4: The SCK pad is driven, with the generated clock, only when its direction bit is 1 and master is 1. Otherwise it is released.
- R5: The SS pad is driven only when its direction bit, the select-output enable and master are all 1. It carries 0 while a frame is busy and 1 otherwise.
- R6: In single-wire master mode MOSI is the shared data pad (driven with `sh_mtx` when its direction bit is 1, and it feeds `sh_rx`). MISO follows its own direction bit and port-data bit.
- R7: In single-wire slave mode MISO is the shared data pad (driven with `sh_stx` under the R2 condition, and it feeds `sh_rx`). MOSI follows its own direction bit and port-data bit.
- R8: In four-wire mode `sh_rx` follows the MISO pad when master and the MOSI pad when slave.
- R9: With the hold bit at 1 and `wait_mode` at 1, the clock level and edge count freeze. After release the frame completes with exactly 2×XFER_BITS clock edges, ends with the clock low and then drops `xfer_busy`.
- R10: With the hold bit at 0, `wait_mode` has no effect on clock generation.
- R11: `sh_lsb_first` follows control bit 3. A frame starts on `xfer_start` only in master mode when no frame is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 direction/port data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pad_in | input | 4 | Pad input levels (MISO, MOSI, SCK, SS at 0..3) |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| sh_mtx | input | 1 | Master transmit bit from shifter |
| sh_stx | input | 1 | Slave transmit bit from shifter |
| sh_rx | output | 1 | Receive bit to shifter |
| sh_sck_in | output | 1 | SCK pad level to shifter |
| sh_ss_in | output | 1 | SS pad level to shifter |
| sh_lsb_first | output | 1 | Bit-order setting to shifter |
| xfer_start | input | 1 | Start a master frame |
| baud_tick | input | 1 | Clock-edge enable from the divider |
| wait_mode | input | 1 | Chip is in wait mode |
| xfer_busy | output | 1 | Master frame in progress |

## Verification
The bench builds the block with XFER_BITS set to 4, so a full frame is eight clock edges. This means a frame can be stopped in the middle by wait mode, held for several cycles, resumed and run to its end within a few dozen cycles. The whole edge count, the final clock level and the busy drop are then checked directly against 2×XFER_BITS. The routing checks walk each pad through master and slave, four-wire and single-wire settings, with the SS pad level and the direction bits changed one at a time.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

    localparam int REG_W  = 8;
    localparam int PIN_N  = 4;

    localparam int PIN_MISO = 0;
    localparam int PIN_MOSI = 1;
    localparam int PIN_SCK  = 2;
    localparam int PIN_SS   = 3;

    typedef struct packed {
        logic [2:0] spare;
        logic       wait_hold;
        logic       lsb_first;
        logic       ss_oe;
        logic       single_wire;
        logic       master;
    } ctrl_t;

    typedef struct packed {
        logic [PIN_N-1:0] port;
        logic [PIN_N-1:0] dir;
    } pinreg_t;

    typedef struct packed {
        logic oe;
        logic val;
    } drive_t;

    function automatic drive_t slave_data(input logic dir_bit, input logic master,
                                          input logic ss_level, input logic tx);
        drive_t d;
        d.oe  = dir_bit & ~master & ~ss_level;
        d.val = tx;
        return d;
    endfunction

    function automatic drive_t master_data(input logic dir_bit, input logic master,
                                           input logic tx);
        drive_t d;
        d.oe  = dir_bit & master;
        d.val = tx;
        return d;
    endfunction

    function automatic drive_t gpio_drive(input logic dir_bit, input logic port_bit);
        drive_t d;
        d.oe  = dir_bit;
        d.val = port_bit;
        return d;
    endfunction

endpackage

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             master,
    output logic             single_wire,
    output logic             ss_oe,
    output logic             lsb_first,
    output logic             wait_hold,
    output logic [PIN_N-1:0] dir,
    output logic [1:0]       port_data
);

    ctrl_t   ctrl_q;
    pinreg_t pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pin_q  <= '0;
        end else if (wr) begin
            if (addr) pin_q  <= pinreg_t'(wdata);
            else      ctrl_q <= ctrl_t'(wdata);
        end
    end

    always_comb begin
        rdata = addr ? REG_W'(pin_q) : REG_W'(ctrl_q);
    end

    assign master      = ctrl_q.master;
    assign single_wire = ctrl_q.single_wire;
    assign ss_oe       = ctrl_q.ss_oe;
    assign lsb_first   = ctrl_q.lsb_first;
    assign wait_hold   = ctrl_q.wait_hold;
    assign dir         = pin_q.dir;
    assign port_data   = {pin_q.port[PIN_MOSI], pin_q.port[PIN_MISO]};

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
    parameter int XFER_BITS = 8,
    localparam int EDGES    = 2 * XFER_BITS,
    localparam int CNT_W    = $clog2(EDGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             master,
    input  logic             tick,
    input  logic             run,
    output logic             sck,
    output logic             busy,
    output logic [CNT_W-1:0] edge_cnt
);

    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck      <= 1'b0;
            busy     <= 1'b0;
            edge_cnt <= '0;
        end else if (!busy) begin
            if (start && master) begin
                busy     <= 1'b1;
                edge_cnt <= '0;
                sck      <= 1'b0;
            end
        end else if (tick && run) begin
            sck <= ~sck;
            if (edge_cnt == LAST_EDGE) begin
                busy     <= 1'b0;
                edge_cnt <= '0;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
    import spi_pin_pkg::*;
(
    input  logic             master,
    input  logic             single_wire,
    input  logic             ss_oe,
    input  logic [PIN_N-1:0] dir,
    input  logic [1:0]       port_data,
    input  logic [PIN_N-1:0] pad_in,
    input  logic             mtx,
    input  logic             stx,
    input  logic             gen_sck,
    input  logic             busy,
    output logic [PIN_N-1:0] pad_out,
    output logic [PIN_N-1:0] pad_oe,
    output logic             rx
);

    drive_t miso_d, mosi_d, sck_d, ss_d;

    always_comb begin
        miso_d = slave_data(dir[PIN_MISO], master, pad_in[PIN_SS], stx);
        mosi_d = master_data(dir[PIN_MOSI], master, mtx);
        rx     = master ? pad_in[PIN_MISO] : pad_in[PIN_MOSI];

        if (single_wire) begin
            if (master) begin
                miso_d = gpio_drive(dir[PIN_MISO], port_data[0]);
                rx     = pad_in[PIN_MOSI];
            end else begin
                mosi_d = gpio_drive(dir[PIN_MOSI], port_data[1]);
                rx     = pad_in[PIN_MISO];
            end
        end

        sck_d.oe  = dir[PIN_SCK] & master;
        sck_d.val = gen_sck;
        ss_d.oe   = dir[PIN_SS] & ss_oe & master;
        ss_d.val  = ~busy;
    end

    always_comb begin
        pad_oe  = '0;
        pad_out = '0;
        pad_oe[PIN_MISO]  = miso_d.oe;
        pad_out[PIN_MISO] = miso_d.val;
        pad_oe[PIN_MOSI]  = mosi_d.oe;
        pad_out[PIN_MOSI] = mosi_d.val;
        pad_oe[PIN_SCK]   = sck_d.oe;
        pad_out[PIN_SCK]  = sck_d.val;
        pad_oe[PIN_SS]    = ss_d.oe;
        pad_out[PIN_SS]   = ss_d.val;
    end

endmodule

// File: rtl/spi_pin_router.sv
module spi_pin_router
    import spi_pin_pkg::*;
#(
    parameter int XFER_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [PIN_N-1:0] pad_in,
    output logic [PIN_N-1:0] pad_out,
    output logic [PIN_N-1:0] pad_oe,
    input  logic             sh_mtx,
    input  logic             sh_stx,
    output logic             sh_rx,
    output logic             sh_sck_in,
    output logic             sh_ss_in,
    output logic             sh_lsb_first,
    input  logic             xfer_start,
    input  logic             baud_tick,
    input  logic             wait_mode,
    output logic             xfer_busy
);

    localparam int CNT_W = $clog2(2 * XFER_BITS);

    logic             master, single_wire, ss_oe, lsb_first, wait_hold;
    logic [PIN_N-1:0] dir;
    logic [1:0]       port_data;
    logic             gen_sck, run;
    logic [CNT_W-1:0] edge_cnt;

    spi_ctrl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .master      (master),
        .single_wire (single_wire),
        .ss_oe       (ss_oe),
        .lsb_first   (lsb_first),
        .wait_hold   (wait_hold),
        .dir         (dir),
        .port_data   (port_data)
    );

    assign run = ~(wait_hold & wait_mode);

    spi_sck_gen #(.XFER_BITS(XFER_BITS)) u_sck (
        .clk      (clk),
        .rst      (rst),
        .start    (xfer_start),
        .master   (master),
        .tick     (baud_tick),
        .run      (run),
        .sck      (gen_sck),
        .busy     (xfer_busy),
        .edge_cnt (edge_cnt)
    );

    spi_pin_mux u_mux (
        .master      (master),
        .single_wire (single_wire),
        .ss_oe       (ss_oe),
        .dir         (dir),
        .port_data   (port_data),
        .pad_in      (pad_in),
        .mtx         (sh_mtx),
        .stx         (sh_stx),
        .gen_sck     (gen_sck),
        .busy        (xfer_busy),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .rx          (sh_rx)
    );

    assign sh_sck_in    = pad_in[PIN_SCK];
    assign sh_ss_in     = pad_in[PIN_SS];
    assign sh_lsb_first = lsb_first;

endmodule

// File: rtl/spi_pin_router_chk.sv
module spi_pin_router_chk
    import spi_pin_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int EDGES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             master,
    input logic             single_wire,
    input logic             ss_oe,
    input logic             wait_hold,
    input logic             wait_mode,
    input logic [PIN_N-1:0] dir,
    input logic [PIN_N-1:0] pad_in,
    input logic [PIN_N-1:0] pad_oe,
    input logic             gen_sck,
    input logic             busy,
    input logic [CNT_W-1:0] edge_cnt
);

    assert_miso_slave_R2: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[PIN_MISO] && !single_wire) |-> (!master && dir[PIN_MISO] && !pad_in[PIN_SS]));

    assert_mosi_master_R3: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[PIN_MOSI] && !single_wire) |-> (master && dir[PIN_MOSI]));

    assert_sck_drive_R4: assert property (@(posedge clk) disable iff (rst)
        pad_oe[PIN_SCK] |-> (master && dir[PIN_SCK]));

    assert_ss_drive_R5: assert property (@(posedge clk) disable iff (rst)
        pad_oe[PIN_SS] |-> (master && ss_oe && dir[PIN_SS]));

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && wait_hold && wait_mode) |=> ($stable(gen_sck) && $stable(edge_cnt)));

    assert_edge_range_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(edge_cnt) < EDGES));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !gen_sck);

endmodule

bind spi_pin_router spi_pin_router_chk #(
    .CNT_W (CNT_W),
    .EDGES (2 * XFER_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .master      (master),
    .single_wire (single_wire),
    .ss_oe       (ss_oe),
    .wait_hold   (wait_hold),
    .wait_mode   (wait_mode),
    .dir         (dir),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .gen_sck     (gen_sck),
    .busy        (xfer_busy),
    .edge_cnt    (edge_cnt)
);

// File: tb/spi_pin_router_tb.sv
module spi_pin_router_tb;

    localparam int BITS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] pad_in = 4'b1000;
    logic [3:0] pad_out, pad_oe;
    logic       sh_mtx = 1'b0, sh_stx = 1'b0;
    logic       sh_rx, sh_sck_in, sh_ss_in, sh_lsb_first;
    logic       xfer_start = 1'b0, baud_tick = 1'b0, wait_mode = 1'b0;
    logic       xfer_busy;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int toggles;
    logic last_sck;

    always #10 clk = ~clk;

    spi_pin_router #(.XFER_BITS(BITS)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .sh_mtx(sh_mtx), .sh_stx(sh_stx),
        .sh_rx(sh_rx), .sh_sck_in(sh_sck_in), .sh_ss_in(sh_ss_in),
        .sh_lsb_first(sh_lsb_first), .xfer_start(xfer_start),
        .baud_tick(baud_tick), .wait_mode(wait_mode), .xfer_busy(xfer_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #2;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic count_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pad_out[2] !== last_sck) toggles++;
            last_sck = pad_out[2];
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd_reg(1'b0, d); chk("R1 ctrl reset", d, 8'h00);
        rd_reg(1'b1, d); chk("R1 pin reset", d, 8'h00);
        chk("R1 no drive", pad_oe, 4'h0);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr_reg(1'b0, 8'hA5); rd_reg(1'b0, d); chk("R1 ctrl readback", d, 8'hA5);
        wr_reg(1'b1, 8'h3C); rd_reg(1'b1, d); chk("R1 pin readback", d, 8'h3C);
        wr_reg(1'b0, 8'h00); wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_normal_slave;
        wr_reg(1'b1, 8'h0F);
        wr_reg(1'b0, 8'h00);
        sh_stx = 1'b1; pad_in = 4'b0010; #2;
        chk("R2 slave MISO driven", {pad_oe[0], pad_out[0]}, 2'b11);
        chk("R3 slave MOSI released", pad_oe[1], 1'b0);
        chk("R4 slave SCK released", pad_oe[2], 1'b0);
        chk("R8 slave rx from MOSI", sh_rx, 1'b1);
        pad_in = 4'b1001; #2;
        chk("R2 SS high releases MISO", pad_oe[0], 1'b0);
        chk("R8 slave rx ignores MISO", sh_rx, 1'b0);
        pad_in = 4'b0000;
        wr_reg(1'b1, 8'h0E);
        chk("R2 dir clear releases MISO", pad_oe[0], 1'b0);
        sh_stx = 1'b0;
    endtask

    task automatic t_normal_master;
        wr_reg(1'b1, 8'h0F);
        wr_reg(1'b0, 8'h05);
        sh_mtx = 1'b1; pad_in = 4'b0001; #2;
        chk("R3 master MOSI driven", {pad_oe[1], pad_out[1]}, 2'b11);
        chk("R2 master MISO released", pad_oe[0], 1'b0);
        chk("R4 master SCK driven idle", {pad_oe[2], pad_out[2]}, 2'b10);
        chk("R5 SS driven high idle", {pad_oe[3], pad_out[3]}, 2'b11);
        chk("R8 master rx from MISO", sh_rx, 1'b1);
        wr_reg(1'b0, 8'h01);
        chk("R5 no SS without enable", pad_oe[3], 1'b0);
        wr_reg(1'b1, 8'h0D);
        chk("R3 dir clear releases MOSI", pad_oe[1], 1'b0);
        wr_reg(1'b1, 8'h0B);
        chk("R4 dir clear releases SCK", pad_oe[2], 1'b0);
        sh_mtx = 1'b0; pad_in = 4'b0000;
    endtask

    task automatic t_single_master;
        wr_reg(1'b0, 8'h03);
        wr_reg(1'b1, 8'h13);
        sh_mtx = 1'b1; pad_in = 4'b0010; #2;
        chk("R6 shared MOSI drives", {pad_oe[1], pad_out[1]}, 2'b11);
        chk("R6 MISO as GPIO out", {pad_oe[0], pad_out[0]}, 2'b11);
        chk("R6 rx from MOSI", sh_rx, 1'b1);
        wr_reg(1'b1, 8'h01);
        chk("R6 MOSI receive when dir 0", pad_oe[1], 1'b0);
        chk("R6 GPIO port bit 0", {pad_oe[0], pad_out[0]}, 2'b10);
        sh_mtx = 1'b0;
    endtask

    task automatic t_single_slave;
        wr_reg(1'b0, 8'h02);
        wr_reg(1'b1, 8'h23);
        sh_stx = 1'b1; pad_in = 4'b0001; #2;
        chk("R7 shared MISO drives", {pad_oe[0], pad_out[0]}, 2'b11);
        chk("R7 MOSI as GPIO out", {pad_oe[1], pad_out[1]}, 2'b11);
        chk("R7 rx from MISO", sh_rx, 1'b1);
        pad_in = 4'b1010; #2;
        chk("R7 SS high releases MISO", pad_oe[0], 1'b0);
        chk("R7 rx ignores MOSI", sh_rx, 1'b0);
        sh_stx = 1'b0; pad_in = 4'b0000;
    endtask

    task automatic t_order;
        wr_reg(1'b0, 8'h08);
        chk("R11 lsb-first routed", sh_lsb_first, 1'b1);
        wr_reg(1'b0, 8'h00);
        chk("R11 msb-first routed", sh_lsb_first, 1'b0);
        @(negedge clk); xfer_start = 1'b1; baud_tick = 1'b1;
        @(negedge clk); xfer_start = 1'b0; baud_tick = 1'b0;
        chk("R11 no start as slave", xfer_busy, 1'b0);
    endtask

    task automatic t_hold;
        wr_reg(1'b1, 8'h0F);
        wr_reg(1'b0, 8'h15);
        @(negedge clk); xfer_start = 1'b1; baud_tick = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        toggles = 0; last_sck = pad_out[2];
        chk("R5 SS low while busy", pad_out[3], 1'b0);
        count_edges(3);
        wait_mode = 1'b1;
        chk("R9 edges before hold", toggles, 3);
        count_edges(6);
        chk("R9 no edges while held", toggles, 3);
        chk("R9 busy while held", xfer_busy, 1'b1);
        wait_mode = 1'b0;
        count_edges(10);
        chk("R9 total edges", toggles, 2 * BITS);
        chk("R9 busy dropped", xfer_busy, 1'b0);
        chk("R9 clock ends low", pad_out[2], 1'b0);
        chk("R5 SS high after frame", pad_out[3], 1'b1);
        baud_tick = 1'b0;
    endtask

    task automatic t_no_hold;
        wr_reg(1'b0, 8'h05);
        wait_mode = 1'b1;
        @(negedge clk); xfer_start = 1'b1; baud_tick = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        toggles = 0; last_sck = pad_out[2];
        count_edges(2 * BITS + 2);
        chk("R10 wait ignored edges", toggles, 2 * BITS);
        chk("R10 frame finished", xfer_busy, 1'b0);
        wait_mode = 1'b0; baud_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_regs();
        t_normal_slave();
        t_normal_master();
        t_single_master();
        t_single_slave();
        t_order();
        t_hold();
        t_no_hold();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule